// File: doc/BRIEF.md
# Dual-register PLD output macrocell

This block is one output cell of a small programmable logic device, written as synthesizable logic clocked by a fast system clock `clk_i`. The cell takes two groups of product terms. Each group is ORed into a sum term, and the width of each group is a parameter between 4 and 8.

The cell holds two flip-flops. Each flip-flop has its own clock term and its own asynchronous reset term. All registers share one synchronous preset. A flip-flop captures on the rising edge of its clock term, which the cell detects by sampling the term on `clk_i`. A reset term clears its register's visible value in the same cycle.

A two-bit source field chooses what drives the pin, and a polarity bit can invert that value. The pin driver is enabled by its own product term. Both registers always feed back to the array, so either one can be buried. A test preload mode writes the pin level into a chosen register. A security-verify condition keeps the driver in high impedance.

Top module: `pld_macrocell2`

## Requirements
- R1: While `rst_ni` is low, both registers clear to 0. The pin value then equals `invert_i` whenever a register is the selected source.
- R2: Sum term 1 is the OR of all bits of `pt1_i` (P1_TERMS wide). Sum term 2 is the OR of all bits of `pt2_i` (P2_TERMS wide).
- R3: When `join_i`=1, register 1 loads sum1 OR sum2. When `join_i`=0, it loads sum1 alone. Register 2 always loads sum2.
- R4: Register k (bit k-1 of `clk_term_i`, `arst_term_i` and `fb_q_o`) updates only in a `clk_i` cycle where its clock term is 1 and was 0 in the previous cycle. A term that is already high when reset is released must first be seen low. The two registers update independently.
- R5: While `arst_term_i[k]` is 1, `fb_q_o[k]` reads 0 in that same cycle and the register is cleared. This reset takes priority over preset, preload and data.
- R6: With `preset_i`=1 and no preload, a clock-term edge loads 1 instead of data.
- R7: With `preload_i`=1, a clock-term edge on the selected register loads `pad_i`. `preload_sel_i`=0 selects register 1 and 1 selects register 2. The other register keeps its value even on its own edge. The loaded value ignores `invert_i`, and preload overrides preset.
- R8: `src_i` chooses the pin value: 0 selects sum1, 1 selects sum1 OR sum2, 2 selects register 1 and 3 selects register 2. `pad_o` is the chosen value XOR `invert_i`.
- R9: `pad_oe_o` = `oe_term_i` AND NOT `preload_i` AND NOT (`secure_i` AND `verify_i`). `pin_fb_o` always equals `pad_i`.
- R10: `fb_q_o` shows both registers whatever the values of `src_i` and `pad_oe_o`.
- R11: While `secure_i` and `verify_i` are both 1, `pad_oe_o` is 0 whatever `oe_term_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the clock terms |
| rst_ni | input | 1 | Active-low power-up clear |
| pt1_i | input | P1_TERMS | Product terms of sum 1 |
| pt2_i | input | P2_TERMS | Product terms of sum 2 |
| clk_term_i | input | 2 | Clock term per register (bit 0 is register 1) |
| arst_term_i | input | 2 | Asynchronous reset term per register |
| preset_i | input | 1 | Shared synchronous preset |
| oe_term_i | input | 1 | Output enable term |
| join_i | input | 1 | OR sum 2 into the data of register 1 |
| src_i | input | 2 | Pin source select |
| invert_i | input | 1 | Output polarity |
| secure_i | input | 1 | Security bit |
| verify_i | input | 1 | Verify mode active |
| preload_i | input | 1 | Preload test mode |
| preload_sel_i | input | 1 | Preload target register |
| pad_i | input | 1 | Pin input path |
| pad_o | output | 1 | Pin output value |
| pad_oe_o | output | 1 | Pin driver enable |
| pin_fb_o | output | 1 | Pin level fed back to the array |
| fb_q_o | output | 2 | Register feedback to the array |

## Verification
The bench builds the cell with P1_TERMS=8 and P2_TERMS=6. These unequal widths let a single-hot walk over each group check that every product term reaches the right sum term. They also give register 1 fourteen terms when sums are joined. A long mixed phase then drives random combinations of reset, preset, preload and clock-term edges into both registers at once. This exercises the priority order on each register independently.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  localparam int unsigned NREG = 2;
  localparam int unsigned MIN_TERMS = 4;
  localparam int unsigned MAX_TERMS = 8;

  typedef enum logic [1:0] {
    SRC_SUM1  = 2'd0,
    SRC_JOIN  = 2'd1,
    SRC_REG1  = 2'd2,
    SRC_REG2  = 2'd3
  } mc_src_e;
endpackage

// File: rtl/pld_mc_flop.sv
module pld_mc_flop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ck_term_i,
  input  logic arst_i,
  input  logic preset_i,
  input  logic load_en_i,
  input  logic hold_i,
  input  logic load_val_i,
  input  logic d_i,
  output logic q_o
);
  logic ck_q, q;
  logic edge_w;

  assign edge_w = ck_term_i & ~ck_q;

  // ck_q resets high: a term already high at release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q <= 1'b1;
      q    <= 1'b0;
    end else begin
      ck_q <= ck_term_i;
      if (arst_i)          q <= 1'b0;
      else if (edge_w) begin
        if (load_en_i)     q <= load_val_i;
        else if (hold_i)   q <= q;
        else if (preset_i) q <= 1'b1;
        else               q <= d_i;
      end
    end
  end

  assign q_o = arst_i ? 1'b0 : q;

  AST_ARST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arst_i |=> (q == 1'b0)); // R5
  AST_NO_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arst_i && !(ck_term_i && !ck_q)) |=> (q == $past(q))); // R4
  AST_PRESET_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arst_i && ck_term_i && !ck_q && preset_i && !load_en_i && !hold_i) |=> q); // R6
  AST_PRELOAD_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arst_i && ck_term_i && !ck_q && load_en_i) |=> (q == $past(load_val_i))); // R7
endmodule

// File: rtl/pld_mc_outsel.sv
module pld_mc_outsel
  import pld_mc_pkg::*;
(
  input  logic            sum1_i,
  input  logic            sum_or_i,
  input  logic [NREG-1:0] q_i,
  input  mc_src_e         src_i,
  input  logic            invert_i,
  input  logic            oe_term_i,
  input  logic            preload_i,
  input  logic            secure_i,
  input  logic            verify_i,
  output logic            pad_o,
  output logic            pad_oe_o
);
  logic pick;

  always_comb begin
    unique case (src_i)
      SRC_SUM1: pick = sum1_i;
      SRC_JOIN: pick = sum_or_i;
      SRC_REG1: pick = q_i[0];
      SRC_REG2: pick = q_i[1];
      default:  pick = 1'b0;
    endcase
  end

  assign pad_o    = pick ^ invert_i;
  assign pad_oe_o = oe_term_i & ~preload_i & ~(secure_i & verify_i);
endmodule

// File: rtl/pld_macrocell2.sv
module pld_macrocell2
  import pld_mc_pkg::*;
#(
  parameter int unsigned P1_TERMS = 8,
  parameter int unsigned P2_TERMS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [P1_TERMS-1:0] pt1_i,
  input  logic [P2_TERMS-1:0] pt2_i,
  input  logic [NREG-1:0]     clk_term_i,
  input  logic [NREG-1:0]     arst_term_i,
  input  logic                preset_i,
  input  logic                oe_term_i,
  input  logic                join_i,
  input  logic [1:0]          src_i,
  input  logic                invert_i,
  input  logic                secure_i,
  input  logic                verify_i,
  input  logic                preload_i,
  input  logic                preload_sel_i,
  input  logic                pad_i,
  output logic                pad_o,
  output logic                pad_oe_o,
  output logic                pin_fb_o,
  output logic [NREG-1:0]     fb_q_o
);
  if (P1_TERMS < MIN_TERMS || P1_TERMS > MAX_TERMS ||
      P2_TERMS < MIN_TERMS || P2_TERMS > MAX_TERMS) begin : g_bad_cfg
    $error("product term count out of range");
  end

  logic            sum1, sum2, sum_or;
  logic [NREG-1:0] d;

  assign sum1   = |pt1_i;
  assign sum2   = |pt2_i;
  assign sum_or = sum1 | sum2;
  assign d[0]   = join_i ? sum_or : sum1;
  assign d[1]   = sum2;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic SEL = 1'(g);
    pld_mc_flop u_flop (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ck_term_i  (clk_term_i[g]),
      .arst_i     (arst_term_i[g]),
      .preset_i   (preset_i),
      .load_en_i  (preload_i && (preload_sel_i == SEL)),
      .hold_i     (preload_i && (preload_sel_i != SEL)),
      .load_val_i (pad_i),
      .d_i        (d[g]),
      .q_o        (fb_q_o[g])
    );
  end

  pld_mc_outsel u_outsel (
    .sum1_i    (sum1),
    .sum_or_i  (sum_or),
    .q_i       (fb_q_o),
    .src_i     (mc_src_e'(src_i)),
    .invert_i  (invert_i),
    .oe_term_i (oe_term_i),
    .preload_i (preload_i),
    .secure_i  (secure_i),
    .verify_i  (verify_i),
    .pad_o     (pad_o),
    .pad_oe_o  (pad_oe_o)
  );

  assign pin_fb_o = pad_i;

  AST_SECURE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secure_i && verify_i) |-> !pad_oe_o); // R11
  AST_PRELOAD_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_i |-> !pad_oe_o); // R9
  AST_ARST_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arst_term_i[0] |-> !fb_q_o[0]); // R5
  AST_SRC_REG2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == 2'd3) |-> (pad_o == (fb_q_o[1] ^ invert_i))); // R8
endmodule

// File: tb/pld_macrocell2_tb_top.sv
module pld_macrocell2_tb_top;
  localparam int P1 = 8;
  localparam int P2 = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [P1-1:0] pt1;
  logic [P2-1:0] pt2;
  logic [1:0]    ck, arst;
  logic          preset, oe, join_c, inv, sec, ver, pl, pl_sel, pad;
  logic [1:0]    src;
  logic          pad_o, pad_oe_o, pin_fb_o;
  logic [1:0]    fb_q_o;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  // reference model state
  bit m_q[2];
  bit m_prev[2];

  always #5 clk = ~clk;

  pld_macrocell2 #(.P1_TERMS(P1), .P2_TERMS(P2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pt1_i(pt1), .pt2_i(pt2),
    .clk_term_i(ck), .arst_term_i(arst), .preset_i(preset), .oe_term_i(oe),
    .join_i(join_c), .src_i(src), .invert_i(inv), .secure_i(sec),
    .verify_i(ver), .preload_i(pl), .preload_sel_i(pl_sel), .pad_i(pad),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o), .pin_fb_o(pin_fb_o), .fb_q_o(fb_q_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 2; r++) begin m_q[r] = 0; m_prev[r] = 1; end
    end else begin
      bit s1, s2;
      bit d[2];
      s1 = (pt1 != 0);
      s2 = (pt2 != 0);
      d[0] = join_c ? (s1 | s2) : s1;
      d[1] = s2;
      for (int r = 0; r < 2; r++) begin
        if (arst[r]) m_q[r] = 0;
        else if (ck[r] && !m_prev[r]) begin
          if (pl) begin
            if (int'(pl_sel) == r) m_q[r] = pad;
          end else if (preset) m_q[r] = 1;
          else m_q[r] = d[r];
        end
        m_prev[r] = ck[r];
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit s1, s2, fq[2], v, eo;
    s1 = (pt1 != 0);
    s2 = (pt2 != 0);
    for (int r = 0; r < 2; r++) fq[r] = arst[r] ? 0 : m_q[r];
    case (src)
      2'd0: v = s1;
      2'd1: v = s1 | s2;
      2'd2: v = fq[0];
      default: v = fq[1];
    endcase
    eo = oe && !pl && !(sec && ver);
    chk(cur_req, "fb_q_o[0]", fb_q_o[0], fq[0]);
    chk(cur_req, "fb_q_o[1]", fb_q_o[1], fq[1]);
    chk(cur_req, "pad_o", pad_o, v ^ inv);
    chk(cur_req, "pad_oe_o", pad_oe_o, eo);
    chk(cur_req, "pin_fb_o", pin_fb_o, pad);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic pulse(input int r);
    ck[r] = 1'b1; tick();
    ck[r] = 1'b0; tick();
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; pt1 = '0; pt2 = '0; ck = '0; arst = '0; preset = 0; oe = 1;
    join_c = 0; src = 2'd2; inv = 0; sec = 0; ver = 0; pl = 0; pl_sel = 0; pad = 0;
    // R1: power-up clear, pin follows polarity
    cur_req = "R1";
    repeat (2) tick();
    chk("R1", "pad_o inv=0", pad_o, 0);
    inv = 1; tick();
    chk("R1", "pad_o inv=1", pad_o, 1);
    chk("R1", "fb_q_o", fb_q_o, 0);
    @(negedge clk); rst_n = 1; inv = 0;
    tick();

    // R2: each product term reaches its sum
    cur_req = "R2"; src = 2'd0;
    for (int i = 0; i < P1; i++) begin
      pt1 = '0; pt1[i] = 1'b1; tick();
      chk("R2", "sum1 term", pad_o, 1);
    end
    pt1 = '0; src = 2'd1;
    for (int i = 0; i < P2; i++) begin
      pt2 = '0; pt2[i] = 1'b1; tick();
      chk("R2", "sum2 term", pad_o, 1);
    end
    pt2 = '0; tick();
    chk("R2", "no term", pad_o, 0);

    // R3: joining sums into register 1
    cur_req = "R3"; src = 2'd2; pt2 = 6'b000100;
    join_c = 1; pulse(0);
    chk("R3", "reg1 joined", fb_q_o[0], 1);
    join_c = 0; pulse(0);
    chk("R3", "reg1 unjoined", fb_q_o[0], 0);
    pulse(1);
    chk("R3", "reg2 sum2", fb_q_o[1], 1);

    // R4: capture only on rising edge of own term
    cur_req = "R4"; pt1 = 8'h01; pt2 = '0;
    ck[0] = 1; tick();
    chk("R4", "reg1 edge", fb_q_o[0], 1);
    chk("R4", "reg2 untouched", fb_q_o[1], 1);
    pt1 = '0; repeat (3) tick();
    chk("R4", "reg1 held high term", fb_q_o[0], 1);
    ck[0] = 0; tick();

    // R5: reset term wins over preset and preload
    cur_req = "R5"; preset = 1; arst[0] = 1; tick();
    chk("R5", "reg1 cleared at once", fb_q_o[0], 0);
    pulse(0);
    chk("R5", "reg1 stays 0 under preset", fb_q_o[0], 0);
    arst[0] = 0; tick();

    // R6: preset loads one
    cur_req = "R6"; pulse(0);
    chk("R6", "reg1 preset", fb_q_o[0], 1);
    preset = 0; pulse(1);
    chk("R6", "reg2 data", fb_q_o[1], 0);

    // R7: preload into chosen register, polarity ignored
    cur_req = "R7"; pl = 1; preset = 1; inv = 1; pl_sel = 1; pad = 1;
    ck = 2'b11; tick(); ck = 2'b00; tick();
    chk("R7", "reg2 preloaded", fb_q_o[1], 1);
    chk("R7", "reg1 held", fb_q_o[0], 1);
    pl_sel = 0; pad = 0; pulse(0);
    chk("R7", "reg1 preloaded 0", fb_q_o[0], 0);
    pl = 0; preset = 0; inv = 0; tick();

    // R8: source sweep with polarity
    cur_req = "R8"; pt1 = 8'h10;
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 2; p++) begin
        src = 2'(s); inv = 1'(p); tick();
      end
    src = 2'd3; inv = 1; tick();
    chk("R8", "reg2 inverted", pad_o, 0);

    // R9/R10/R11: enable, pin path and feedback
    cur_req = "R9"; oe = 0; pad = 1; tick();
    chk("R9", "oe low", pad_oe_o, 0);
    chk("R9", "pin path", pin_fb_o, 1);
    cur_req = "R10"; src = 2'd0; tick();
    chk("R10", "reg2 feedback buried", fb_q_o[1], 1);
    cur_req = "R11"; oe = 1; sec = 1; ver = 1; tick();
    chk("R11", "secure verify hiz", pad_oe_o, 0);
    ver = 0; tick();
    chk("R11", "secure only", pad_oe_o, 1);
    sec = 0;

    // mixed priorities over reset, preset, preload and edges
    cur_req = "R5";
    for (int n = 0; n < 4000; n++) begin
      pt1 = P1'($urandom); pt2 = P2'($urandom);
      if (($urandom % 2) == 0) begin pt1 = '0; pt2 = '0; end
      ck = 2'($urandom);
      arst[0] = (($urandom % 8) == 0);
      arst[1] = (($urandom % 8) == 0);
      preset = (($urandom % 4) == 0);
      pl = (($urandom % 4) == 0);
      pl_sel = 1'($urandom); pad = 1'($urandom);
      join_c = 1'($urandom); src = 2'($urandom); inv = 1'($urandom);
      oe = 1'($urandom); sec = 1'($urandom); ver = 1'($urandom);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule